// File: doc/BRIEF.md
# RF Level Sample Statistics Engine

This block collects readings from a 10-bit converter that digitises the output of a logarithmic RF detector. It reports one statistic per command. A host issues a command code and the block starts a run. During the run a sample-interval timer starts each conversion through a start/done handshake with an external converter interface. The block then folds each returned reading into a running sum, a running maximum and a running minimum.

When the last sample of the run has been folded in, the block raises a one-cycle valid pulse with the statistic on the result bus. It then returns to idle. The statistic is one of five:
- the latest reading;
- the rounded mean of 128 readings;
- the rounded mean of 1024 readings;
- the largest of 1024 readings;
- the smallest of 1024 readings.

At the default interval of 2815 cycles at 50 MHz, one reading is taken every 56.3 µs. A 1024-reading window therefore spans about 58 ms. That is long enough to catch both the crest and the trough of an AM envelope modulated at 20 Hz, so peak level and modulation depth can be derived from two runs.

The controller has five states:
- IDLE waits for a command.
- WAIT counts down the interval.
- START drives the conversion strobe for one cycle.
- CONV waits for the converter's done pulse.
- DONE presents the valid pulse.

It has seven transitions:
- IDLE to WAIT on an accepted command.
- WAIT to START on the timer tick.
- START to CONV unconditionally.
- CONV to WAIT on done when more samples remain.
- CONV to DONE on done with the final sample.
- DONE to IDLE unconditionally.
- All other conditions hold the state.

Top module: `rf_level_stats`

## Requirements
- R1: After reset, `busy`, `result_valid` and `adc_start` are all low.
- R2: A command is accepted only when `cmd_valid` is high while the block is idle and `cmd_mode` is one of these codes: 0 = latest sample, 1 = mean of 128, 2 = mean of 1024, 3 = maximum of 1024, 4 = minimum of 1024. `busy` is high from the cycle after acceptance until the run ends.
- R3: The first `adc_start` pulse appears INTERVAL clock cycles after the accepting edge. Later pulses in the same run follow at exactly INTERVAL-cycle spacing, and each pulse is one cycle wide.
- R4: Code 0 takes one sample and reports that reading unchanged.
- R5: Code 1 reports (sum of 128 readings + 64) >> 7, which rounds half up.
- R6: Code 2 reports (sum of 1024 readings + 512) >> 10. A 20-bit sum holds 1024 full-scale readings without overflow.
- R7: Code 3 reports the largest of 1024 readings. The running maximum starts at 0 for each run.
- R8: Code 4 reports the smallest of 1024 readings. The running minimum starts at 1023 for each run.
- R9: `result_valid` is high for exactly one cycle, in the cycle after the final `adc_done`. `busy` is low in the following cycle. `result` holds its value until the next accepted command.
- R10: A command presented while a run is in progress is ignored. The run keeps its mode and its sample count.
- R11: Command codes 5, 6 and 7 are ignored. No run starts and `busy` stays low.
- R12: Each run issues exactly 1, 128 or 1024 `adc_start` pulses, according to its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 3 | Command code (0..4) |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | One-cycle conversion complete |
| adc_data | input | SAMPLE_W | Reading, valid with `adc_done` |
| busy | output | 1 | Run in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | SAMPLE_W | Reported statistic |

## Verification
A corrupted accumulator, extreme register or mode latch shows up as a wrong `result` value. It is seen only on the `result_valid` pulse that closes the run, which can be up to 1024 intervals later.

A wrong sample counter or timer shows up much sooner, in the `adc_start` pulses. Their count differs from 1, 128 or 1024, or their spacing differs from INTERVAL, on the first pulse that goes astray.

The sample patterns are chosen to expose each kind of fault at the ports:
- Constant full-scale and zero patterns expose wrong preset values and a sum that wraps.
- Alternating 511/512 readings expose the rounding direction.
- A scrambled sequence exposes a lost or duplicated sample.

// File: rtl/rfls_pkg.sv
package rfls_pkg;

    typedef enum logic [2:0] {
        MODE_ONE    = 3'd0,
        MODE_AVG_S  = 3'd1,
        MODE_AVG_L  = 3'd2,
        MODE_PEAK   = 3'd3,
        MODE_TROUGH = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_START,
        S_CONV,
        S_DONE
    } state_e;

    function automatic logic mode_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/rfls_tick_timer.sv
module rfls_tick_timer #(
    parameter int INTERVAL = 2815
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R3
    interval_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/rfls_stats.sv
module rfls_stats
    import rfls_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int ACC_W     = 20,
    parameter int SHORT_LOG = 7,
    parameter int LONG_LOG  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  mode_e               mode,
    input  logic                sample_en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                last,
    output logic [SAMPLE_W-1:0] result
);
    localparam int CNT_W = LONG_LOG + 1;
    localparam logic [ACC_W:0] HALF_S = (ACC_W+1)'(1) << (SHORT_LOG - 1);
    localparam logic [ACC_W:0] HALF_L = (ACC_W+1)'(1) << (LONG_LOG - 1);
    localparam logic [CNT_W-1:0] END_S = CNT_W'((1 << SHORT_LOG) - 1);
    localparam logic [CNT_W-1:0] END_L = CNT_W'((1 << LONG_LOG) - 1);
    localparam logic [SAMPLE_W-1:0] SMAX = '1;

    logic [ACC_W-1:0]    acc_q;
    logic [SAMPLE_W-1:0] max_q, min_q, held_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    end_idx;
    logic [ACC_W:0]      sum_s, sum_l;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q  <= '0;
            max_q  <= '0;
            min_q  <= SMAX;
            held_q <= '0;
            cnt_q  <= '0;
        end else if (sample_en) begin
            acc_q  <= acc_q + ACC_W'(sample);
            held_q <= sample;
            cnt_q  <= cnt_q + 1'b1;
            if (sample > max_q) max_q <= sample;
            if (sample < min_q) min_q <= sample;
        end
    end

    always_comb begin
        case (mode)
            MODE_ONE:   end_idx = '0;
            MODE_AVG_S: end_idx = END_S;
            default:    end_idx = END_L;
        endcase
    end

    assign last  = (cnt_q == end_idx);
    assign sum_s = {1'b0, acc_q} + HALF_S;
    assign sum_l = {1'b0, acc_q} + HALF_L;

    always_comb begin
        case (mode)
            MODE_ONE:    result = held_q;
            MODE_AVG_S:  result = SAMPLE_W'(sum_s >> SHORT_LOG);
            MODE_AVG_L:  result = SAMPLE_W'(sum_l >> LONG_LOG);
            MODE_PEAK:   result = max_q;
            MODE_TROUGH: result = min_q;
            default:     result = '0;
        endcase
    end

    // R7 R8
    extremes_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (max_q >= min_q));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, acc_q} <= (ACC_W+1)'(cnt_q) * (ACC_W+1)'(SMAX));

    // R12
    sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(1 << LONG_LOG));

endmodule

// File: rtl/rfls_ctrl.sv
module rfls_ctrl
    import rfls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_mode,
    input  logic       tick,
    input  logic       adc_done,
    input  logic       last,
    output logic       accept,
    output mode_e      mode_q,
    output logic       busy,
    output logic       adc_start,
    output logic       sample_en,
    output logic       result_valid
);
    state_e state_q, state_d;

    assign accept = (state_q == S_IDLE) && cmd_valid && mode_known(cmd_mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= MODE_ONE;
        end else begin
            state_q <= state_d;
            if (accept) mode_q <= mode_e'(cmd_mode);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_WAIT;
            S_WAIT:  if (tick) state_d = S_START;
            S_START: state_d = S_CONV;
            S_CONV:  if (adc_done) state_d = last ? S_DONE : S_WAIT;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy         = (state_q != S_IDLE);
        adc_start    = (state_q == S_START);
        sample_en    = (state_q == S_CONV) && adc_done;
        result_valid = (state_q == S_DONE);
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> (!result_valid && !busy));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ((state_q == S_IDLE) || $stable(mode_q)));

endmodule

// File: rtl/rf_level_stats.sv
module rf_level_stats
    import rfls_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int ACC_W     = 20,
    parameter int SHORT_LOG = 7,
    parameter int LONG_LOG  = 10,
    parameter int INTERVAL  = 2815
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_mode,
    output logic                adc_start,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                busy,
    output logic                result_valid,
    output logic [SAMPLE_W-1:0] result
);
    logic  accept, tick, last, sample_en;
    mode_e mode_q;

    rfls_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_mode     (cmd_mode),
        .tick         (tick),
        .adc_done     (adc_done),
        .last         (last),
        .accept       (accept),
        .mode_q       (mode_q),
        .busy         (busy),
        .adc_start    (adc_start),
        .sample_en    (sample_en),
        .result_valid (result_valid)
    );

    rfls_tick_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (busy),
        .tick  (tick)
    );

    rfls_stats #(
        .SAMPLE_W  (SAMPLE_W),
        .ACC_W     (ACC_W),
        .SHORT_LOG (SHORT_LOG),
        .LONG_LOG  (LONG_LOG)
    ) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .mode      (mode_q),
        .sample_en (sample_en),
        .sample    (adc_data),
        .last      (last),
        .result    (result)
    );

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_start && !result_valid));

endmodule

// File: tb/test_rf_level_stats.sv
`timescale 1ns/1ps
module test_rf_level_stats;
    localparam int IVL = 8;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_mode = 3'd0;
    logic       adc_start, busy, result_valid;
    logic       adc_done = 1'b0;
    logic [9:0] adc_data = '0;
    logic [9:0] result;

    int compared = 0, mismatched = 0;
    int cyc = 0, accept_cyc = 0, prev_start = 0, starts = 0, gap_bad = 0;
    int pend = 0, kidx = 0, pat = 0;
    logic prev_lvl = 1'b0;

    rf_level_stats #(.INTERVAL(IVL)) i_rf_level_stats (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
        .busy(busy), .result_valid(result_valid), .result(result)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sval(input int p, input int k);
        case (p)
            0: return k % 1024;
            1: return 1023;
            2: return 0;
            3: return (k * 389 + 77) % 1024;
            4: return (k % 2 == 1) ? 512 : 511;
            default: return (k * 37 + 300) % 700 + 100;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // converter model and start monitor, all at the falling edge
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                adc_done = 1'b1;
                adc_data = 10'(sval(pat, kidx));
                kidx++;
            end
        end
        if (adc_start) begin
            if (prev_lvl) gap_bad++;
            if (starts == 0) begin
                if (cyc - accept_cyc != IVL) gap_bad++;
            end else if (cyc - prev_start != IVL) begin
                gap_bad++;
            end
            prev_start = cyc;
            starts++;
            pend = LAT;
        end
        prev_lvl = adc_start;
    end

    task automatic do_run(input int m, input int p, input bit inject, input string req);
        int n, sum, mx, mn, exp, lim;
        bit injected;
        n = (m == 0) ? 1 : (m == 1) ? 128 : 1024;
        sum = 0; mx = 0; mn = 1023;
        for (int k = 0; k < n; k++) begin
            sum += sval(p, k);
            if (sval(p, k) > mx) mx = sval(p, k);
            if (sval(p, k) < mn) mn = sval(p, k);
        end
        case (m)
            0: exp = sval(p, 0);
            1, 2: exp = (sum + n / 2) / n;
            3: exp = mx;
            default: exp = mn;
        endcase
        @(negedge clk);
        pat = p; kidx = 0; starts = 0; gap_bad = 0;
        cmd_valid = 1'b1; cmd_mode = 3'(m);
        @(negedge clk);
        accept_cyc = cyc;
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        lim = 0; injected = 0;
        while (!result_valid && lim < (n + 4) * IVL * 2) begin
            @(negedge clk);
            lim++;
            if (inject && !injected && starts == 10) begin
                cmd_valid = 1'b1; cmd_mode = 3'd3; injected = 1;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        check(result_valid == 1'b1, {req, " valid seen"}, int'(result_valid), 1);
        check(int'(result) == exp, req, int'(result), exp);
        check(starts == n, "R12 start count", starts, n);
        check(gap_bad == 0, "R3 start spacing/width", gap_bad, 0);
        @(negedge clk);
        check(!result_valid && !busy, "R9 pulse end", int'({result_valid, busy}), 0);
        repeat (5) @(negedge clk);
        check(int'(result) == exp, "R9 result held", int'(result), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !result_valid && !adc_start, "R1 reset outputs",
              int'({busy, result_valid, adc_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 idle after reset", int'(busy), 0);

        do_run(0, 3, 0, "R4 single scrambled");
        do_run(0, 1, 0, "R4 single full scale");
        do_run(0, 2, 0, "R4 single zero");
        do_run(1, 0, 0, "R5 mean128 ramp");
        do_run(1, 4, 0, "R5 mean128 half-up");
        do_run(1, 5, 0, "R5 mean128 mixed");
        do_run(2, 1, 0, "R6 mean1024 full scale");
        do_run(2, 3, 0, "R6 mean1024 scrambled");
        do_run(2, 4, 0, "R6 mean1024 half-up");
        do_run(3, 2, 0, "R7 max preset zero");
        do_run(3, 3, 0, "R7 max scrambled");
        do_run(4, 1, 0, "R8 min preset full");
        do_run(4, 3, 0, "R8 min scrambled");
        do_run(1, 0, 1, "R10 busy command ignored");

        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            starts = 0;
            cmd_valid = 1'b1; cmd_mode = 3'(c);
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (3 * IVL) @(negedge clk);
            check(!busy && starts == 0, "R11 unknown code ignored", starts + int'(busy), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule